// File: doc/BRIEF.md
# Byte-to-Word Disk Data Bridge

This block joins an 8-bit processor I/O bus to a disk interface whose data register is 16 bits wide. It watches the low byte of each I/O address and recognises eight disk register ports and one controller port. Every disk register except the data register is passed through as a single byte on the low half of the disk bus. The data register is reached as a pair of byte accesses that a one-bit phase toggle and a holding byte turn into one 16-bit disk transfer.

On a read pair, the first access starts the disk read. It returns the low byte and keeps the high byte. The second access returns the kept byte without touching the disk. On a write pair, the first access only stores its byte. The second access issues one disk write that carries the new byte in the upper half and the stored byte in the lower half. Any access to another disk register or to the controller port puts the toggle back to its first phase.

Strobes are single-cycle and synchronous. The disk-side strobes, the register select and the returned CPU data are combinational from the current access. The toggle and the holding byte update on the clock edge that ends the access.

Top module: `dbb_bridge`

## Requirements
- R1: A disk register is selected when the address byte matches binary 101sss11. The disk register select output equals bits 4:2 of the address (sss), and sss = 000 is the data register. An address outside that pattern and other than E3h produces no disk strobe.
- R2: After reset the toggle is in its first phase. With no access in progress, all strobes are low and the CPU read data is 00h.
- R3: A first-phase read of the data port (A3h) raises the disk read strobe in the same cycle with register select 0. It returns disk data bits 7:0 and stores disk data bits 15:8.
- R4: A second-phase read of the data port raises no disk strobe and returns the stored byte.
- R5: A first-phase write of the data port raises no disk strobe and stores the written byte.
- R6: A second-phase write of the data port raises the disk write strobe once. Disk write data is {new byte, stored byte}.
- R7: An access to a non-data disk register is a single 8-bit transfer. It gives one disk strobe with the decoded select, disk write data {00h, byte}, and CPU read data equal to disk data bits 7:0. It also returns the toggle to the first phase.
- R8: An access to port E3h raises no disk strobe and returns the toggle to the first phase. A write there pulses the controller write output; a read there returns 00h.
- R9: An access to an unmatched port leaves the toggle and the stored byte unchanged. It raises no strobe and returns 00h.
- R10: Reads and writes share one toggle. A write in the second phase after a first-phase read writes {new byte, stored read high byte}. A read in the second phase after a first-phase write returns the byte that was written.
- R11: When read and write strobes arrive together, the access is a write. The disk read and write strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 8 | Low byte of the I/O address |
| cpu_wdata | input | 8 | Byte written by the CPU |
| cpu_rd | input | 1 | I/O read strobe, one cycle per access |
| cpu_wr | input | 1 | I/O write strobe, one cycle per access |
| cpu_rdata | output | 8 | Byte returned to the CPU |
| ctl_wr | output | 1 | Write pulse for the controller port |
| dsk_reg | output | 3 | Disk register select |
| dsk_rd | output | 1 | Disk read strobe |
| dsk_wr | output | 1 | Disk write strobe |
| dsk_wdata | output | 16 | Disk write data |
| dsk_rdata | input | 16 | Disk read data |

## Verification
Two read pairs with different disk words show that the low and high bytes land in the right phase and that the second phase is served from the holding byte. Write pairs do the same for byte order on the disk bus. A data access broken by a side register, by the controller port or by an unmatched port shows which accesses clear the toggle and which leave the pair intact. Mixed read/write pairs, a reset in mid-pair and simultaneous strobes separate the shared-toggle behaviour from a design with separate read and write toggles.

// File: rtl/dbb_pkg.sv
package dbb_pkg;

   // Kind of access decoded from one CPU cycle
   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_DATA = 2'd1,
      ACC_SIDE = 2'd2,
      ACC_CTL  = 2'd3
   } dbb_acc_e;

endpackage

// File: rtl/dbb_decode.sv
module dbb_decode #(
   parameter int               ADDR_W    = 8,
   parameter int               SEL_W     = 3,
   parameter int               SEL_LSB   = 2,
   parameter logic [ADDR_W-1:0] DSK_MASK  = 8'hE3,
   parameter logic [ADDR_W-1:0] DSK_MATCH = 8'hA3,
   parameter logic [ADDR_W-1:0] CTL_PORT  = 8'hE3,
   parameter logic [SEL_W-1:0]  DATA_SEL  = '0
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd,
   input  logic              wr,
   output dbb_pkg::dbb_acc_e acc,
   output logic              is_wr,
   output logic [SEL_W-1:0]  sel
);
   import dbb_pkg::*;

   logic hit_dsk;
   logic hit_ctl;
   logic active;

   always_comb begin
      hit_dsk = ((addr & DSK_MASK) == DSK_MATCH);
      hit_ctl = (addr == CTL_PORT);
      active  = rd | wr;
      is_wr   = wr;                       // write wins on a double strobe
      sel     = addr[SEL_LSB +: SEL_W];
      acc     = ACC_NONE;
      if (active) begin
         if (hit_ctl)
            acc = ACC_CTL;
         else if (hit_dsk)
            acc = (sel == DATA_SEL) ? ACC_DATA : ACC_SIDE;
      end
   end

endmodule

// File: rtl/dbb_pair_ctrl.sv
module dbb_pair_ctrl #(
   parameter int CPU_W      = 8,
   parameter bit HOLD_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  dbb_pkg::dbb_acc_e acc,
   input  logic              is_wr,
   input  logic [CPU_W-1:0]  wbyte,
   input  logic [CPU_W-1:0]  rd_hi,
   output logic              phase,
   output logic [CPU_W-1:0]  hold
);
   import dbb_pkg::*;

   logic             phase_nx;
   logic             hold_ld;
   logic [CPU_W-1:0] hold_nx;

   always_comb begin
      phase_nx = phase;
      hold_ld  = 1'b0;
      hold_nx  = is_wr ? wbyte : rd_hi;
      unique case (acc)
         ACC_DATA: begin
            phase_nx = ~phase;
            hold_ld  = ~phase;
         end
         ACC_SIDE, ACC_CTL: phase_nx = 1'b0;
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) phase <= 1'b0;
      else        phase <= phase_nx;
   end

   generate
      if (HOLD_RESET) begin : g_hold_rst
         always_ff @(posedge clk) begin
            if (!rst_n)       hold <= '0;
            else if (hold_ld) hold <= hold_nx;
         end
      end else begin : g_hold_free
         always_ff @(posedge clk) begin
            if (hold_ld) hold <= hold_nx;
         end
      end
   endgenerate

   AST_DATA_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
      (acc == ACC_DATA) |=> (phase != $past(phase)));                     // R3
   AST_SIDE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (acc == ACC_SIDE || acc == ACC_CTL) |=> !phase);                    // R7
   AST_STRAY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (acc == ACC_NONE) |=> ($stable(phase) && $stable(hold)));          // R9
   AST_ODD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (acc == ACC_DATA && phase) |=> $stable(hold));                      // R4

endmodule

// File: rtl/dbb_xfer.sv
module dbb_xfer #(
   parameter int CPU_W = 8,
   parameter int DSK_W = 16,
   parameter int SEL_W = 3
) (
   input  dbb_pkg::dbb_acc_e acc,
   input  logic              is_wr,
   input  logic              phase,
   input  logic [SEL_W-1:0]  sel,
   input  logic [CPU_W-1:0]  wbyte,
   input  logic [CPU_W-1:0]  hold,
   input  logic [DSK_W-1:0]  dsk_rdata,
   output logic [CPU_W-1:0]  cpu_rdata,
   output logic              ctl_wr,
   output logic [SEL_W-1:0]  dsk_reg,
   output logic              dsk_rd,
   output logic              dsk_wr,
   output logic [DSK_W-1:0]  dsk_wdata
);
   import dbb_pkg::*;

   localparam int PAD_W = DSK_W - CPU_W;

   logic [DSK_W-1:0] side_word;
   logic [DSK_W-1:0] pair_word;

   generate
      if (PAD_W > CPU_W) begin : g_wide
         assign pair_word = {{(PAD_W-CPU_W){1'b0}}, wbyte, hold};
      end else begin : g_exact
         assign pair_word = {wbyte, hold};
      end
   endgenerate

   assign side_word = {{PAD_W{1'b0}}, wbyte};
   assign dsk_reg   = sel;

   always_comb begin
      cpu_rdata = '0;
      ctl_wr    = 1'b0;
      dsk_rd    = 1'b0;
      dsk_wr    = 1'b0;
      dsk_wdata = '0;
      unique case (acc)
         ACC_DATA: begin
            if (is_wr) begin
               dsk_wr    = phase;
               dsk_wdata = phase ? pair_word : '0;
            end else begin
               dsk_rd    = ~phase;
               cpu_rdata = phase ? hold : dsk_rdata[CPU_W-1:0];
            end
         end
         ACC_SIDE: begin
            if (is_wr) begin
               dsk_wr    = 1'b1;
               dsk_wdata = side_word;
            end else begin
               dsk_rd    = 1'b1;
               cpu_rdata = dsk_rdata[CPU_W-1:0];
            end
         end
         ACC_CTL: ctl_wr = is_wr;
         default: ;
      endcase
   end

endmodule

// File: rtl/dbb_bridge.sv
module dbb_bridge #(
   parameter int                ADDR_W     = 8,
   parameter int                CPU_W      = 8,
   parameter int                DSK_W      = 16,
   parameter int                SEL_W      = 3,
   parameter int                SEL_LSB    = 2,
   parameter logic [ADDR_W-1:0] DSK_MASK   = 8'hE3,
   parameter logic [ADDR_W-1:0] DSK_MATCH  = 8'hA3,
   parameter logic [ADDR_W-1:0] CTL_PORT   = 8'hE3,
   parameter logic [SEL_W-1:0]  DATA_SEL   = '0,
   parameter bit                HOLD_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [CPU_W-1:0]  cpu_wdata,
   input  logic              cpu_rd,
   input  logic              cpu_wr,
   output logic [CPU_W-1:0]  cpu_rdata,
   output logic              ctl_wr,
   output logic [SEL_W-1:0]  dsk_reg,
   output logic              dsk_rd,
   output logic              dsk_wr,
   output logic [DSK_W-1:0]  dsk_wdata,
   input  logic [DSK_W-1:0]  dsk_rdata
);
   import dbb_pkg::*;

   localparam logic [ADDR_W-1:0] SEL_FIELD = ADDR_W'(((1 << SEL_W) - 1) << SEL_LSB);

   generate
      if (DSK_W != 2 * CPU_W) begin : g_bad_width
         $error("dbb_bridge: disk width must be twice the CPU width");
      end
      if (SEL_LSB + SEL_W > ADDR_W) begin : g_bad_field
         $error("dbb_bridge: register select field exceeds address byte");
      end
      if ((DSK_MASK & SEL_FIELD) != '0) begin : g_bad_mask
         $error("dbb_bridge: match mask overlaps register select field");
      end
   endgenerate

   dbb_acc_e         acc;
   logic             is_wr;
   logic [SEL_W-1:0] sel;
   logic             phase;
   logic [CPU_W-1:0] hold;

   dbb_decode #(
      .ADDR_W(ADDR_W), .SEL_W(SEL_W), .SEL_LSB(SEL_LSB),
      .DSK_MASK(DSK_MASK), .DSK_MATCH(DSK_MATCH),
      .CTL_PORT(CTL_PORT), .DATA_SEL(DATA_SEL)
   ) u_dec (
      .addr(cpu_addr), .rd(cpu_rd), .wr(cpu_wr),
      .acc(acc), .is_wr(is_wr), .sel(sel)
   );

   dbb_pair_ctrl #(.CPU_W(CPU_W), .HOLD_RESET(HOLD_RESET)) u_pair (
      .clk(clk), .rst_n(rst_n), .acc(acc), .is_wr(is_wr),
      .wbyte(cpu_wdata), .rd_hi(dsk_rdata[DSK_W-1 -: CPU_W]),
      .phase(phase), .hold(hold)
   );

   dbb_xfer #(.CPU_W(CPU_W), .DSK_W(DSK_W), .SEL_W(SEL_W)) u_xfer (
      .acc(acc), .is_wr(is_wr), .phase(phase), .sel(sel),
      .wbyte(cpu_wdata), .hold(hold), .dsk_rdata(dsk_rdata),
      .cpu_rdata(cpu_rdata), .ctl_wr(ctl_wr), .dsk_reg(dsk_reg),
      .dsk_rd(dsk_rd), .dsk_wr(dsk_wr), .dsk_wdata(dsk_wdata)
   );

   AST_DSK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(dsk_rd && dsk_wr));                                              // R11
   AST_ODD_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (acc == ACC_DATA && !is_wr && phase) |-> !dsk_rd);                 // R4
   AST_EVEN_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (acc == ACC_DATA && is_wr && !phase) |-> !dsk_wr);                 // R5
   AST_CTL_NO_DSK: assert property (@(posedge clk) disable iff (!rst_n)
      (acc == ACC_CTL) |-> (!dsk_rd && !dsk_wr));                        // R8
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_rd && !cpu_wr) |-> (!dsk_rd && !dsk_wr && !ctl_wr));         // R2

endmodule

// File: tb/tb_dbb_bridge.sv
module tb_dbb_bridge;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0;
   logic        cpu_rd = 1'b0;
   logic        cpu_wr = 1'b0;
   logic [7:0]  cpu_rdata;
   logic        ctl_wr;
   logic [2:0]  dsk_reg;
   logic        dsk_rd;
   logic        dsk_wr;
   logic [15:0] dsk_wdata;
   logic [15:0] dsk_rdata = '0;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   // sampled outputs of the last access
   logic [7:0]  s_rdata;
   logic        s_ctl, s_rd, s_wr;
   logic [2:0]  s_reg;
   logic [15:0] s_wdata;

   always #10 clk = ~clk;

   dbb_bridge dut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata), .ctl_wr(ctl_wr),
      .dsk_reg(dsk_reg), .dsk_rd(dsk_rd), .dsk_wr(dsk_wr),
      .dsk_wdata(dsk_wdata), .dsk_rdata(dsk_rdata)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // one bus cycle; outputs sampled 5 ns before the closing edge
   task automatic cyc(input logic [7:0] a, input logic r, input logic w, input logic [7:0] d);
      @(negedge clk);
      cpu_addr = a; cpu_rd = r; cpu_wr = w; cpu_wdata = d;
      #5;
      s_rdata = cpu_rdata; s_ctl = ctl_wr; s_rd = dsk_rd; s_wr = dsk_wr;
      s_reg = dsk_reg; s_wdata = dsk_wdata;
      @(posedge clk); #1;
      cpu_rd = 1'b0; cpu_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a); cyc(a, 1'b1, 1'b0, 8'h00); endtask
   task automatic wr(input logic [7:0] a, input logic [7:0] d); cyc(a, 1'b0, 1'b1, d); endtask

   task automatic do_reset;
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   task automatic t_reset;
      cyc(8'hA3, 1'b0, 1'b0, 8'h00);   // idle cycle
      chk("R2", "idle dsk_rd", s_rd, 0);
      chk("R2", "idle dsk_wr", s_wr, 0);
      chk("R2", "idle ctl_wr", s_ctl, 0);
      chk("R2", "idle rdata", s_rdata, 0);
      dsk_rdata = 16'h4411;
      rd(8'hA3);
      chk("R2", "first read after reset hits disk", s_rd, 1);
      rd(8'hA3);                      // close the pair
   endtask

   task automatic t_data_read;
      dsk_rdata = 16'hBEEF;
      rd(8'hA3);
      chk("R3", "rd strobe", s_rd, 1);
      chk("R3", "reg select", s_reg, 0);
      chk("R3", "low byte", s_rdata, 8'hEF);
      dsk_rdata = 16'h0000;
      rd(8'hA3);
      chk("R4", "no rd strobe", s_rd, 0);
      chk("R4", "stored high", s_rdata, 8'hBE);
      dsk_rdata = 16'h1234;
      rd(8'hA3);
      chk("R3", "low byte 2", s_rdata, 8'h34);
      rd(8'hA3);
      chk("R4", "stored high 2", s_rdata, 8'h12);
   endtask

   task automatic t_data_write;
      wr(8'hA3, 8'h34);
      chk("R5", "no wr strobe", s_wr, 0);
      chk("R5", "no rd strobe", s_rd, 0);
      wr(8'hA3, 8'h12);
      chk("R6", "wr strobe", s_wr, 1);
      chk("R6", "word", s_wdata, 16'h1234);
      chk("R6", "reg select", s_reg, 0);
      wr(8'hA3, 8'hCD);
      wr(8'hA3, 8'hAB);
      chk("R6", "word 2", s_wdata, 16'hABCD);
   endtask

   task automatic t_decode;
      for (int r = 1; r < 8; r++) begin
         logic [7:0] a;
         a = 8'hA3 | 8'(r << 2);
         dsk_rdata = {8'hC0, 8'(8'h40 + r)};
         rd(a);
         chk("R1", "side rd strobe", s_rd, 1);
         chk("R1", "side select", s_reg, r);
         chk("R7", "side rdata", s_rdata, 8'h40 + r);
         wr(a, 8'(8'h90 + r));
         chk("R7", "side wr strobe", s_wr, 1);
         chk("R7", "side wdata", s_wdata, 16'h0090 + r);
      end
      rd(8'hA0);
      chk("R1", "A0 no rd", s_rd, 0);
      wr(8'hA1, 8'h77);
      chk("R1", "A1 no wr", s_wr, 0);
      rd(8'h23);
      chk("R1", "23 no rd", s_rd, 0);
   endtask

   task automatic t_side_resets;
      dsk_rdata = 16'h5566;
      rd(8'hA3);                       // phase now second
      rd(8'hA7);                       // side register clears toggle
      rd(8'hA3);
      chk("R7", "read restarts pair", s_rd, 1);
      chk("R7", "read restart low", s_rdata, 8'h66);
      rd(8'hA3);
      wr(8'hA3, 8'h55);
      wr(8'hAB, 8'h00);
      wr(8'hA3, 8'h66);
      chk("R7", "write restarts pair", s_wr, 0);
      wr(8'hA3, 8'h77);
      chk("R7", "restarted word", s_wdata, 16'h7766);
   endtask

   task automatic t_ctl;
      dsk_rdata = 16'h2211;
      rd(8'hA3);
      wr(8'hE3, 8'h80);
      chk("R8", "ctl_wr pulse", s_ctl, 1);
      chk("R8", "ctl no dsk wr", s_wr, 0);
      chk("R8", "ctl no dsk rd", s_rd, 0);
      rd(8'hA3);
      chk("R8", "pair restarted", s_rd, 1);
      rd(8'hE3);
      chk("R8", "ctl read data", s_rdata, 0);
      chk("R8", "ctl read no ctl_wr", s_ctl, 0);
      chk("R8", "ctl read no dsk rd", s_rd, 0);
      rd(8'hA3);
      chk("R8", "pair restarted by ctl read", s_rd, 1);
      rd(8'hA3);
   endtask

   task automatic t_unmatched;
      wr(8'hA3, 8'h5A);
      wr(8'h00, 8'hFF);
      chk("R9", "stray wr none", s_wr | s_rd | s_ctl, 0);
      rd(8'h40);
      chk("R9", "stray rd none", s_wr | s_rd | s_ctl, 0);
      chk("R9", "stray rdata", s_rdata, 0);
      wr(8'hA3, 8'h12);
      chk("R9", "pair kept wr", s_wr, 1);
      chk("R9", "pair kept word", s_wdata, 16'h125A);
      dsk_rdata = 16'hCAFE;
      rd(8'hA3);
      rd(8'hE7);
      dsk_rdata = 16'h0000;
      rd(8'hA3);
      chk("R9", "pair kept rd quiet", s_rd, 0);
      chk("R9", "pair kept high", s_rdata, 8'hCA);
   endtask

   task automatic t_mixed;
      dsk_rdata = 16'h7788;
      rd(8'hA3);
      chk("R10", "mixed low", s_rdata, 8'h88);
      wr(8'hA3, 8'h99);
      chk("R10", "mixed wr strobe", s_wr, 1);
      chk("R10", "mixed word", s_wdata, 16'h9977);
      wr(8'hA3, 8'h11);
      rd(8'hA3);
      chk("R10", "mixed rd quiet", s_rd, 0);
      chk("R10", "mixed rd byte", s_rdata, 8'h11);
   endtask

   task automatic t_both;
      cyc(8'hA7, 1'b1, 1'b1, 8'h3C);
      chk("R11", "both wr", s_wr, 1);
      chk("R11", "both no rd", s_rd, 0);
      chk("R11", "both wdata", s_wdata, 16'h003C);
   endtask

   task automatic t_reset_mid;
      wr(8'hA3, 8'h01);
      do_reset();
      wr(8'hA3, 8'h02);
      chk("R2", "reset mid-pair clears toggle", s_wr, 0);
      wr(8'hA3, 8'h03);
      chk("R2", "post-reset word", s_wdata, 16'h0302);
   endtask

   initial begin
      do_reset();
      t_reset();
      t_data_read();
      t_data_write();
      t_decode();
      t_side_resets();
      t_ctl();
      t_unmatched();
      t_mixed();
      t_both();
      t_reset_mid();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      #3_000_000;
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

endmodule